// File: doc/BRIEF.md
# Motor Control PWM Generator

This block generates pulse-width modulated gate commands for up to four inverter half-bridges. One shared counter sets the switching period. It runs either as a sawtooth (count up, then wrap) or as a triangle (count up, then count down). Each of the four pairs holds its own duty threshold. The high-side output of a pair is active while the counter is below that threshold.

A pair can run in one of two ways. In complementary mode the low side is the inverse of the high side, and every rising edge is held back by a programmable number of clocks, so the two switches of a leg never conduct together. In independent mode both pins follow the compare result directly.

After the pair logic, each pin passes through a polarity inverter and a software override. The counter also emits a one-cycle pulse once per period, which an A/D converter can use as its sampling trigger. All settings are reached through a small synchronous write bus with a combinational read port.

Top module: `mcpwm_top`

## Requirements
- R1: Synchronous reset behaviour.
  - After a synchronous reset the counter is stopped at 0 and every setting is 0.
  - All high-side pins (even indices) read 0 and all low-side pins (odd indices) read 1, so `pwm_out` = 8'hAA.
  - `adc_trig` is 0.
- R2: Register map. A write with `bus_we` high is taken at the clock edge. `bus_rdata` returns the addressed register combinationally.
  - Address 0: control. Bit 0 enables counting; bit 1 selects the triangle (center-aligned) mode.
  - Address 1: period.
  - Address 2: dead time.
  - Address 3: independent-mode mask, one bit per pair.
  - Address 4: polarity mask, one bit per pin.
  - Address 5: override enable, one bit per pin.
  - Address 6: override level, one bit per pin.
  - Addresses 8 to 11: duty buffers for pairs 0 to 3.
- R3: Edge-aligned mode.
  - The counter steps 0, 1, …, P and then wraps to 0, so the period is P+1 clocks.
  - A pair's compare result is 1 while the counter is below its active duty value.
  - While stopped, the compare result is 0.
- R4: Center-aligned mode.
  - The counter rises from 0 to P and then falls back to 0, so the period is 2·P clocks.
  - The compare rule of R3 applies unchanged.
- R5: `adc_trig` pulses high for one clock once per period.
  - In edge-aligned mode it pulses in the cycle where the counter equals P, just before the wrap.
  - In center-aligned mode it pulses where the counter reaches 0 while counting down.
- R6: Duty values are double-buffered.
  - A written duty value becomes active only at the clock edge that ends a trigger cycle.
  - While the counter is stopped, it becomes active at the next edge.
- R7: Complementary mode with dead time.
  - The low side of a pair (pin 2i+1) is the inverse of its high side (pin 2i).
  - Each side turns on only after its input has been on for the dead-time number of clocks, and it turns off at once.
  - The two sides of a pair are never both active.
- R8: Independent mode. Both pins of a pair carry the compare result with no dead-time delay.
- R9: A polarity bit of 1 inverts its pin.
- R10: An override-enable bit of 1 drives its pin to the matching override-level bit, whatever the PWM value and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pwm_out | output | 8 | Gate commands; pin 2i is the high side and pin 2i+1 the low side of pair i |
| adc_trig | output | 1 | One-clock converter trigger per period |

## Verification
A corrupted counter or direction bit shows on `adc_trig` within one period. The pulse spacing moves away from P+1 or 2·P, and the pin edges shift in the same cycle that the counter takes a wrong value. A stale or early-loaded active duty value moves a pin edge in the first period after the buffer write. A dead-time counter that is off by one moves a rising edge by one clock, or lets both pins of a leg overlap, in the very cycle of the transition. Every one of these faults therefore differs from a per-clock reference model within at most one period.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_PER   = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_DEAD  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_INDEP = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_POL   = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_OEN   = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_OVAL  = 4'd6;
    localparam int unsigned        ADR_DUTY0 = 8;

    typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    function automatic logic pin_level(logic v, logic inv, logic force_en, logic force_val);
        return force_en ? force_val : (v ^ inv);
    endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         center,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         bnd
);

    cnt_dir_e dir;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            dir <= CNT_UP;
        end else if (!center) begin
            dir <= CNT_UP;
            cnt <= (cnt >= period) ? '0 : cnt + 1'b1;
        end else if (dir == CNT_UP) begin
            if (cnt >= period) begin
                dir <= CNT_DOWN;
                cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                dir <= CNT_UP;
                cnt <= (period == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        if (!run)        bnd = 1'b0;
        else if (center) bnd = (dir == CNT_DOWN) && (cnt == '0);
        else             bnd = (cnt >= period);
    end

    // R5
    trig_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && !center) |=> (cnt == '0));

endmodule

// File: rtl/mcpwm_pair.sv
module mcpwm_pair
    import mcpwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] dead,
    input  logic         indep,
    output leg_t         leg
);

    logic       raw;
    logic [1:0] side_in;
    logic [1:0] side_out;

    assign raw        = run && (cnt < duty);
    assign side_in[0] = raw;
    assign side_in[1] = indep ? raw : !raw;

    for (genvar k = 0; k < 2; k++) begin : g_side
        logic [W-1:0] hold;
        always_ff @(posedge clk) begin
            if (rst || !side_in[k]) hold <= '0;
            else if (hold < dead)   hold <= hold + 1'b1;
        end
        assign side_out[k] = indep ? side_in[k] : (side_in[k] && (hold >= dead));
    end

    assign leg.hi = side_out[0];
    assign leg.lo = side_out[1];

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !indep |-> !(leg.hi && leg.lo));

    // R7
    dt_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(leg.hi) && !indep && (dead != '0)) |-> $past(raw));

endmodule

// File: rtl/mcpwm_top.sv
module mcpwm_top
    import mcpwm_pkg::*;
#(
    parameter int unsigned W     = 16,
    parameter int unsigned NPAIR = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [W-1:0]         bus_wdata,
    output logic [W-1:0]         bus_rdata,
    output logic [2*NPAIR-1:0]   pwm_out,
    output logic                 adc_trig
);

    localparam int unsigned NPIN = 2 * NPAIR;

    logic             run, center;
    logic [W-1:0]     period, dead;
    logic [NPAIR-1:0] indep;
    logic [NPIN-1:0]  pol, oen, oval;
    logic [W-1:0]     duty_buf [NPAIR];
    logic [W-1:0]     duty_act [NPAIR];
    logic [W-1:0]     cnt;
    logic             bnd;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            center <= 1'b0;
            period <= '0;
            dead   <= '0;
            indep  <= '0;
            pol    <= '0;
            oen    <= '0;
            oval   <= '0;
            for (int i = 0; i < NPAIR; i++) duty_buf[i] <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                ADR_CTRL:  begin run <= bus_wdata[0]; center <= bus_wdata[1]; end
                ADR_PER:   period <= bus_wdata;
                ADR_DEAD:  dead   <= bus_wdata;
                ADR_INDEP: indep  <= bus_wdata[NPAIR-1:0];
                ADR_POL:   pol    <= bus_wdata[NPIN-1:0];
                ADR_OEN:   oen    <= bus_wdata[NPIN-1:0];
                ADR_OVAL:  oval   <= bus_wdata[NPIN-1:0];
                default: begin
                    for (int i = 0; i < NPAIR; i++)
                        if (bus_addr == ADDR_W'(ADR_DUTY0 + i)) duty_buf[i] <= bus_wdata;
                end
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_CTRL:  bus_rdata = {{(W-2){1'b0}}, center, run};
            ADR_PER:   bus_rdata = period;
            ADR_DEAD:  bus_rdata = dead;
            ADR_INDEP: bus_rdata = W'(indep);
            ADR_POL:   bus_rdata = W'(pol);
            ADR_OEN:   bus_rdata = W'(oen);
            ADR_OVAL:  bus_rdata = W'(oval);
            default: begin
                for (int i = 0; i < NPAIR; i++)
                    if (bus_addr == ADDR_W'(ADR_DUTY0 + i)) bus_rdata = duty_buf[i];
            end
        endcase
    end

    mcpwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst(rst), .run(run), .center(center),
        .period(period), .cnt(cnt), .bnd(bnd)
    );

    assign adc_trig = bnd;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        leg_t leg;

        always_ff @(posedge clk) begin
            if (rst)              duty_act[p] <= '0;
            else if (!run || bnd) duty_act[p] <= duty_buf[p];
        end

        mcpwm_pair #(.W(W)) u_pair (
            .clk(clk), .rst(rst), .run(run), .cnt(cnt),
            .duty(duty_act[p]), .dead(dead), .indep(indep[p]), .leg(leg)
        );

        assign pwm_out[2*p]   = pin_level(leg.hi, pol[2*p],   oen[2*p],   oval[2*p]);
        assign pwm_out[2*p+1] = pin_level(leg.lo, pol[2*p+1], oen[2*p+1], oval[2*p+1]);

        // R6
        duty_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (run && !bnd) |=> $stable(duty_act[p]));
    end

endmodule

// File: tb/mcpwm_top_tb.sv
module mcpwm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pwm_out;
    logic        adc_trig;

    always #4 clk = ~clk;

    mcpwm_top u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .adc_trig(adc_trig)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string phase = "R1 reset";

    // behavioural reference state
    int m_run, m_center, m_down, m_cnt, m_per, m_dt, m_ind, m_pol, m_oen, m_oval;
    int m_dbuf [4];
    int m_dact [4];
    int m_hold [8];
    int t_bnd, t_cnt, t_down;
    int t_hold [8];

    function automatic int side_in(int k);
        int r;
        r = (m_run != 0 && m_cnt < m_dact[k/2]) ? 1 : 0;
        if (k % 2 == 0 || m_ind[k/2]) return r;
        return 1 - r;
    endfunction

    function automatic int model_bnd();
        if (m_run == 0) return 0;
        if (m_center != 0) return (m_down != 0 && m_cnt == 0) ? 1 : 0;
        return (m_cnt >= m_per) ? 1 : 0;
    endfunction

    function automatic logic [7:0] model_pins();
        logic [7:0] v;
        for (int k = 0; k < 8; k++) begin
            int s, o;
            s = side_in(k);
            o = m_ind[k/2] ? s : ((s != 0 && m_hold[k] >= m_dt) ? 1 : 0);
            v[k] = m_oen[k] ? m_oval[k] : (o[0] ^ m_pol[k]);
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_center = 0; m_down = 0; m_cnt = 0; m_per = 0; m_dt = 0;
            m_ind = 0; m_pol = 0; m_oen = 0; m_oval = 0;
            for (int i = 0; i < 4; i++) begin m_dbuf[i] = 0; m_dact[i] = 0; end
            for (int k = 0; k < 8; k++) m_hold[k] = 0;
        end else begin
            for (int k = 0; k < 8; k++)
                t_hold[k] = (side_in(k) == 0) ? 0 : ((m_hold[k] < m_dt) ? m_hold[k] + 1 : m_hold[k]);
            t_bnd = model_bnd();
            t_cnt = m_cnt; t_down = m_down;
            if (m_run == 0) begin
                t_cnt = 0; t_down = 0;
            end else if (m_center == 0) begin
                t_down = 0;
                t_cnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
            end else if (m_down == 0) begin
                if (m_cnt >= m_per) begin t_down = 1; t_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else t_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin t_down = 0; t_cnt = (m_per == 0) ? 0 : 1; end
                else t_cnt = m_cnt - 1;
            end
            if (m_run == 0 || t_bnd != 0)
                for (int i = 0; i < 4; i++) m_dact[i] = m_dbuf[i];
            for (int k = 0; k < 8; k++) m_hold[k] = t_hold[k];
            m_cnt = t_cnt; m_down = t_down;
            if (bus_we) begin
                case (bus_addr)
                    4'd0: begin m_run = bus_wdata[0]; m_center = bus_wdata[1]; end
                    4'd1: m_per  = bus_wdata;
                    4'd2: m_dt   = bus_wdata;
                    4'd3: m_ind  = bus_wdata[3:0];
                    4'd4: m_pol  = bus_wdata[7:0];
                    4'd5: m_oen  = bus_wdata[7:0];
                    4'd6: m_oval = bus_wdata[7:0];
                    4'd8, 4'd9, 4'd10, 4'd11: m_dbuf[bus_addr - 4'd8] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (!rst) begin
            chk({phase, " pins"}, 32'(pwm_out), 32'(model_pins()));
            chk({phase, " R5 trigger"}, 32'(adc_trig), 32'(model_bnd()));
            if (m_pol == 0 && m_oen == 0)
                for (int i = 0; i < 4; i++)
                    if (!m_ind[i]) chk("R7 leg overlap", 32'(pwm_out[2*i] & pwm_out[2*i+1]), 32'd0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            n_fail++;
            $display("FAIL watchdog expired in phase %s: actual=%0d expected<%0d", phase, cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(int a, int exp);
        @(negedge clk);
        bus_addr = 4'(a);
        #1;
        chk("R2 readback", 32'(bus_rdata), 32'(exp));
    endtask

    task automatic trig_gap(int exp, string tag);
        int n;
        do @(negedge clk); while (!adc_trig);
        n = 0;
        do begin @(negedge clk); n++; end while (!adc_trig);
        chk(tag, n, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset pins", 32'(pwm_out), 32'h0000_00AA);
        chk("R1 reset trigger", 32'(adc_trig), 32'd0);
        rst = 1'b0;

        phase = "R2 setup";
        wr(1, 9); wr(2, 0);
        wr(8, 3); wr(9, 5); wr(10, 0); wr(11, 12);
        rd(1, 9); rd(9, 5); rd(11, 12); rd(0, 0);

        phase = "R3 edge";
        wr(0, 1);
        rd(0, 1);
        trig_gap(10, "R5 edge period P+1");
        repeat (30) @(negedge clk);

        phase = "R6 reload";
        wr(8, 7); wr(9, 1);
        repeat (25) @(negedge clk);

        phase = "R7 deadtime";
        wr(2, 3);
        repeat (40) @(negedge clk);

        phase = "R4 center";
        wr(0, 3);
        repeat (40) @(negedge clk);
        trig_gap(18, "R5 center period 2P");
        wr(10, 6);
        repeat (40) @(negedge clk);

        phase = "R8 independent";
        wr(3, 10);
        rd(3, 10);
        repeat (40) @(negedge clk);

        phase = "R9 polarity";
        wr(4, 8'h0F);
        repeat (40) @(negedge clk);

        phase = "R10 override";
        wr(5, 8'hC3); wr(6, 8'h41);
        repeat (30) @(negedge clk);
        chk("R10 forced pins", 32'(pwm_out & 8'hC3), 32'h41);

        phase = "R6 stopped";
        wr(5, 0); wr(0, 0); wr(8, 2);
        repeat (20) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule